// File: doc/BRIEF.md
# Timer Software Event Unit

This block lets software fire timer events by writing a one-byte event word. The block holds a 16-bit up-counter that advances through a programmable prescaler. It also holds three capture/compare channels with their registers, the interrupt and overcapture flags, and the interrupt enables. A set bit in the event word acts only in the cycle of the write, so nothing remains pending afterwards.

The update event restarts the counter and the hidden prescaler count. It also moves the staged prescaler and reload values into the working copies that drive counting. A channel event behaves according to the channel's direction bit. In capture direction it copies the live counter into the channel register, raises the channel flag, and flags an overcapture if the channel flag was still set. In compare direction it only raises the flag. The trigger event raises the trigger flag. Flags remain set until software clears them through a separate clear strobe. A single interrupt line combines every flag whose enable is set.

Top module: `tmr_evt_top`

## Requirements
- R1: While reset is high, the counter, all three channel registers, all seven flags and the interrupt output are 0. The working prescaler value is 0 (divide by one) and the working reload value is all ones.
- R2: Event word encoding: bit 0 is update, bits 1, 2 and 3 are the events for channels 0, 1 and 2, and bit 6 is trigger. Bits 4, 5 and 7 change no flag, counter or channel register.
- R3: An event acts only on the clock edge that samples the write. A bit written as 0 does nothing. A cleared flag is not raised again without a new write.
- R4: An update event sets the counter to 0 and restarts the prescaler count. The next counter step then comes exactly prescaler+1 cycles later.
- R5: Prescaler and reload writes go to staged copies. They take effect only on an update event or on a counter wrap, not before.
- R6: The counter steps by one each time the prescaler count reaches the working prescaler value. After it reaches the working reload value, its next step goes to 0.
- R7: A channel event in compare direction (direction bit 0) sets that channel's flag and leaves its register unchanged.
- R8: A channel event in capture direction (direction bit 1) loads the counter value present before the edge into that channel's register and sets its flag.
- R9: A capture-direction channel event that arrives while the channel flag is already set also sets the channel's overcapture flag. The flag word is: bits 2:0 channel flags, bit 3 trigger flag, bits 6:4 channel overcapture flags.
- R10: A trigger event sets the trigger flag (flag bit 3).
- R11: Flags hold until a clear strobe writes 0 in their bit position. A 1 in a position keeps that flag. If a set and a clear fall in the same cycle, the set wins.
- R12: The interrupt output is high exactly when a channel or trigger flag is set and its enable is set. Enable bits 2:0 belong to the channels and bit 3 to trigger. Overcapture flags never raise the interrupt.
- R13: When an update and a capture are written in the same cycle, the register receives the counter value from before the restart and the counter becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_we | input | 1 | Event word write strobe |
| evt_data | input | 8 | Event word |
| ctl_we | input | 1 | Control write strobe |
| ctl_in_mode | input | 3 | Per-channel direction, 1 = capture |
| ctl_irq_en | input | 4 | Interrupt enables, bit 3 trigger |
| psc_we | input | 1 | Staged prescaler write strobe |
| psc_data | input | 16 | Prescaler value, divides by value+1 |
| arr_we | input | 1 | Staged reload write strobe |
| arr_data | input | 16 | Reload value |
| flg_we | input | 1 | Flag clear strobe |
| flg_keep | input | 7 | 0 clears the flag in that position |
| cnt_o | output | 16 | Live counter |
| ccr_o | output | 48 | Channel registers, channel n at bits 16n+15:16n |
| flags_o | output | 7 | Flag word |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act on the same edge. An update and a capture can share one write. The bench reads the counter just before that edge and then expects the channel register to hold that value while the counter reads 0. A flag set and a flag clear can also coincide. The bench raises a channel event together with a clear strobe that zeroes the same flag and expects the flag to remain set. Prescaler restart is judged by issuing an update in the middle of a prescale period and counting the cycles until the next counter step.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    localparam int CNT_W   = 16;
    localparam int NCH     = 3;
    localparam int EVT_W   = 8;
    localparam int IE_W    = NCH + 1;
    localparam int FLG_W   = 2 * NCH + 1;

    // Bit positions inside the event word
    localparam int UPD_POS = 0;
    localparam int CC_POS  = 1;
    localparam int TRG_POS = 6;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic           upd;
        logic           trg;
        logic [NCH-1:0] cc;
    } evt_t;

    // Packs as {oc, trg, cc}: flag word bits 6:4, 3, 2:0
    typedef struct packed {
        logic [NCH-1:0] oc;
        logic           trg;
        logic [NCH-1:0] cc;
    } flags_t;

    function automatic evt_t evt_decode(input logic we, input logic [EVT_W-1:0] d);
        evt_t e;
        e.upd = we & d[UPD_POS];
        e.trg = we & d[TRG_POS];
        for (int i = 0; i < NCH; i++) begin
            e.cc[i] = we & d[CC_POS + i];
        end
        return e;
    endfunction

endpackage

// File: rtl/tmr_evt_base.sv
module tmr_evt_base #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic         psc_we,
    input  logic [W-1:0] psc_data,
    input  logic         arr_we,
    input  logic [W-1:0] arr_data,
    output logic [W-1:0] cnt
);

    logic [W-1:0] psc_sh, psc_act, arr_sh, arr_act, pcnt;
    logic         tick, wrap;

    assign tick = (pcnt == psc_act);
    assign wrap = tick && (cnt == arr_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_sh  <= '0;
            psc_act <= '0;
            arr_sh  <= '1;
            arr_act <= '1;
            pcnt    <= '0;
            cnt     <= '0;
        end else begin
            if (psc_we) psc_sh <= psc_data;
            if (arr_we) arr_sh <= arr_data;
            if (upd) begin
                pcnt    <= '0;
                cnt     <= '0;
                psc_act <= psc_sh;
                arr_act <= arr_sh;
            end else if (tick) begin
                pcnt <= '0;
                if (wrap) begin
                    cnt     <= '0;
                    psc_act <= psc_sh;
                    arr_act <= arr_sh;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_mode,
    input  logic         cc_evt,
    input  logic [W-1:0] cnt,
    input  logic         clr_flag,
    input  logic         clr_oc,
    output logic [W-1:0] ccr,
    output logic         flag,
    output logic         oc
);

    logic capture;
    assign capture = cc_evt && in_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr  <= '0;
            flag <= 1'b0;
            oc   <= 1'b0;
        end else begin
            if (capture) ccr <= cnt;

            if (cc_evt)        flag <= 1'b1;
            else if (clr_flag) flag <= 1'b0;

            if (capture && flag) oc <= 1'b1;
            else if (clr_oc)     oc <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] cc_flag,
    input  logic         trg_flag,
    input  logic [N:0]   irq_en,
    output logic         irq
);

    logic [N:0] pend;
    assign pend = {trg_flag, cc_flag} & irq_en;
    assign irq  = |pend;

endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
    import tmr_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_we,
    input  logic [EVT_W-1:0]     evt_data,
    input  logic                 ctl_we,
    input  logic [NCH-1:0]       ctl_in_mode,
    input  logic [IE_W-1:0]      ctl_irq_en,
    input  logic                 psc_we,
    input  logic [CNT_W-1:0]     psc_data,
    input  logic                 arr_we,
    input  logic [CNT_W-1:0]     arr_data,
    input  logic                 flg_we,
    input  logic [FLG_W-1:0]     flg_keep,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [NCH*CNT_W-1:0] ccr_o,
    output logic [FLG_W-1:0]     flags_o,
    output logic                 irq_o
);

    evt_t           evt;
    flags_t         clr, flg;
    logic [NCH-1:0] mode_q;
    logic [IE_W-1:0] ie_q;
    logic           trg_q;
    cnt_t           cnt;

    always_comb begin
        evt = evt_decode(evt_we, evt_data);
        clr = flags_t'(flg_we ? ~flg_keep : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ie_q   <= '0;
            trg_q  <= 1'b0;
        end else begin
            if (ctl_we) begin
                mode_q <= ctl_in_mode;
                ie_q   <= ctl_irq_en;
            end
            if (evt.trg)      trg_q <= 1'b1;
            else if (clr.trg) trg_q <= 1'b0;
        end
    end

    tmr_evt_base #(.W(CNT_W)) i_base (
        .clk      (clk),
        .rst      (rst),
        .upd      (evt.upd),
        .psc_we   (psc_we),
        .psc_data (psc_data),
        .arr_we   (arr_we),
        .arr_data (arr_data),
        .cnt      (cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cnt_t ccr_i;
        tmr_evt_chan #(.W(CNT_W)) i_chan (
            .clk      (clk),
            .rst      (rst),
            .in_mode  (mode_q[i]),
            .cc_evt   (evt.cc[i]),
            .cnt      (cnt),
            .clr_flag (clr.cc[i]),
            .clr_oc   (clr.oc[i]),
            .ccr      (ccr_i),
            .flag     (flg.cc[i]),
            .oc       (flg.oc[i])
        );
        assign ccr_o[i*CNT_W +: CNT_W] = ccr_i;
    end

    assign flg.trg = trg_q;

    tmr_evt_irq #(.N(NCH)) i_irq (
        .cc_flag  (flg.cc),
        .trg_flag (flg.trg),
        .irq_en   (ie_q),
        .irq      (irq_o)
    );

    assign cnt_o   = cnt;
    assign flags_o = flg;

endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk
    import tmr_evt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 evt_we,
    input logic [EVT_W-1:0]     evt_data,
    input logic [NCH-1:0]       in_mode,
    input logic [IE_W-1:0]      irq_en,
    input logic [CNT_W-1:0]     cnt_o,
    input logic [NCH*CNT_W-1:0] ccr_o,
    input logic [FLG_W-1:0]     flags_o,
    input logic                 irq_o
);

    // R4
    upd_restart_chk: assert property (@(posedge clk) disable iff (rst)
        evt_we && evt_data[UPD_POS] |=> cnt_o == '0);

    // R10
    trg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt_we && evt_data[TRG_POS] |=> flags_o[NCH]);

    // R12
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> |flags_o[NCH:0]);

    // R12
    trg_irq_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o[NCH] && irq_en[NCH] |-> irq_o);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R8
        cap_value_chk: assert property (@(posedge clk) disable iff (rst)
            evt_we && evt_data[CC_POS+i] && in_mode[i]
            |=> ccr_o[i*CNT_W +: CNT_W] == $past(cnt_o));

        // R7
        cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
            evt_we && evt_data[CC_POS+i] && !in_mode[i]
            |=> ccr_o[i*CNT_W +: CNT_W] == $past(ccr_o[i*CNT_W +: CNT_W]));

        // R9
        overcap_chk: assert property (@(posedge clk) disable iff (rst)
            evt_we && evt_data[CC_POS+i] && in_mode[i] && flags_o[i]
            |=> flags_o[NCH+1+i]);

        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            evt_we && evt_data[CC_POS+i] |=> flags_o[i]);
    end

endmodule

bind tmr_evt_top tmr_evt_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_we   (evt_we),
    .evt_data (evt_data),
    .in_mode  (mode_q),
    .irq_en   (ie_q),
    .cnt_o    (cnt_o),
    .ccr_o    (ccr_o),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
);

// File: tb/test_tmr_evt_top.sv
`timescale 1ns/1ps
module test_tmr_evt_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_we = 1'b0;
    logic [7:0]  evt_data = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_in_mode = '0;
    logic [3:0]  ctl_irq_en = '0;
    logic        psc_we = 1'b0;
    logic [15:0] psc_data = '0;
    logic        arr_we = 1'b0;
    logic [15:0] arr_data = '0;
    logic        flg_we = 1'b0;
    logic [6:0]  flg_keep = '1;
    logic [15:0] cnt_o;
    logic [47:0] ccr_o;
    logic [6:0]  flags_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tmr_evt_top i_tmr_evt_top (
        .clk(clk), .rst(rst), .evt_we(evt_we), .evt_data(evt_data),
        .ctl_we(ctl_we), .ctl_in_mode(ctl_in_mode), .ctl_irq_en(ctl_irq_en),
        .psc_we(psc_we), .psc_data(psc_data), .arr_we(arr_we), .arr_data(arr_data),
        .flg_we(flg_we), .flg_keep(flg_keep), .cnt_o(cnt_o), .ccr_o(ccr_o),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic       clr;
        logic [2:0] mode;
        logic [3:0] ie;
        logic [7:0] evt;
        logic [6:0] fl;
        logic       irq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'b000, 4'b0000, 8'h02, 7'b0000001, 1'b0}, // R7 compare flag
        '{1'b1, 3'b000, 4'b0001, 8'h02, 7'b0000001, 1'b1}, // R12 enabled
        '{1'b1, 3'b111, 4'b0000, 8'h0E, 7'b0000111, 1'b0}, // R8 three captures
        '{1'b0, 3'b111, 4'b0000, 8'h04, 7'b0100111, 1'b0}, // R9 overcapture ch1
        '{1'b1, 3'b000, 4'b1000, 8'h40, 7'b0001000, 1'b1}, // R10 trigger
        '{1'b1, 3'b000, 4'b1111, 8'hB0, 7'b0000000, 1'b0}, // R2 reserved bits
        '{1'b1, 3'b000, 4'b1111, 8'h00, 7'b0000000, 1'b0}, // R3 zero word
        '{1'b1, 3'b000, 4'b0010, 8'h08, 7'b0000100, 1'b0}, // R12 other enable
        '{1'b1, 3'b100, 4'b0000, 8'h08, 7'b0000100, 1'b0}  // R8 ch2 capture
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_evt(input logic [7:0] v);
        evt_we = 1'b1; evt_data = v;
        step();
        evt_we = 1'b0; evt_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        logic [15:0] v;
        repeat (3) step();
        // R1 reset state
        check("R1 cnt", cnt_o, 0);
        check("R1 ccr", ccr_o, 0);
        check("R1 flags", flags_o, 0);
        check("R1 irq", irq_o, 0);
        rst = 1'b0;

        // Vector table
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].clr) begin flg_we = 1'b1; flg_keep = '0; end
            ctl_we = 1'b1; ctl_in_mode = VECS[k].mode; ctl_irq_en = VECS[k].ie;
            step();
            flg_we = 1'b0; flg_keep = '1; ctl_we = 1'b0;
            wr_evt(VECS[k].evt);
            check($sformatf("vec%0d flags R2/R7-R10", k), flags_o, VECS[k].fl);
            check($sformatf("vec%0d irq R12", k), irq_o, VECS[k].irq);
        end

        // R12 overcapture alone does not raise irq
        flg_we = 1'b1; flg_keep = 7'b1110000; ctl_we = 1'b1; ctl_in_mode = 3'b111; ctl_irq_en = 4'b1111;
        step();
        flg_we = 1'b0; flg_keep = '1; ctl_we = 1'b0;
        wr_evt(8'h02); wr_evt(8'h02);
        flg_we = 1'b1; flg_keep = 7'b1111110;
        step();
        flg_we = 1'b0; flg_keep = '1;
        check("R12 oc only flags", flags_o[3:0], 0);
        check("R12 oc no irq", irq_o, 0);

        // R11 set wins over clear; then clear alone; R3 no re-raise
        flg_we = 1'b1; flg_keep = '0; ctl_we = 1'b1; ctl_in_mode = 3'b000; ctl_irq_en = 4'b0000;
        step();
        ctl_we = 1'b0;
        flg_keep = 7'b1111110; evt_we = 1'b1; evt_data = 8'h02;
        step();
        evt_we = 1'b0; evt_data = '0; flg_we = 1'b0; flg_keep = '1;
        check("R11 set wins", flags_o[0], 1);
        repeat (3) step();
        check("R11 flag holds", flags_o[0], 1);
        flg_we = 1'b1; flg_keep = 7'b1111110;
        step();
        flg_we = 1'b0; flg_keep = '1;
        check("R11 cleared", flags_o[0], 0);
        repeat (3) step();
        check("R3 no re-raise", flags_o, 0);

        // R6/R5 prescaler staging
        c = cnt_o; step();
        check("R6 step div1", cnt_o, c + 16'd1);
        psc_we = 1'b1; psc_data = 16'd3; step(); psc_we = 1'b0;
        c = cnt_o; step();
        check("R5 staged not active", cnt_o, c + 16'd1);
        wr_evt(8'h01);
        check("R4 update clears cnt", cnt_o, 0);
        repeat (3) step();
        check("R5 div4 still 0", cnt_o, 0);
        step();
        check("R5 div4 step", cnt_o, 1);
        // R4 mid-period update restarts prescaler
        repeat (2) step();
        wr_evt(8'h01);
        repeat (3) step();
        check("R4 prescaler restarted 0", cnt_o, 0);
        step();
        check("R4 prescaler restarted 1", cnt_o, 1);

        // R6 wrap at reload
        psc_we = 1'b1; psc_data = 16'd0; arr_we = 1'b1; arr_data = 16'd4;
        step();
        psc_we = 1'b0; arr_we = 1'b0;
        wr_evt(8'h01);
        repeat (4) step();
        check("R6 reach reload", cnt_o, 4);
        step();
        check("R6 wrap", cnt_o, 0);

        arr_we = 1'b1; arr_data = 16'hFFFF; step(); arr_we = 1'b0;
        wr_evt(8'h01);
        repeat (20) step();

        // R8 capture value
        ctl_we = 1'b1; ctl_in_mode = 3'b011; step(); ctl_we = 1'b0;
        c = cnt_o;
        wr_evt(8'h02);
        check("R8 capture value", ccr_o[15:0], c);

        // R13 update with capture
        repeat (5) step();
        c = cnt_o;
        wr_evt(8'h05);
        check("R13 captured pre-restart", ccr_o[31:16], c);
        check("R13 counter restarted", cnt_o, 0);

        // R7 compare leaves register
        ctl_we = 1'b1; ctl_in_mode = 3'b000; step(); ctl_we = 1'b0;
        v = ccr_o[15:0];
        repeat (4) step();
        wr_evt(8'h02);
        check("R7 register unchanged", ccr_o[15:0], v);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule